// File: doc/BRIEF.md
# Split-Word Five-Tap FIR Filter

This block is a five-tap direct-form FIR filter for 32-bit signed samples and 16-bit signed coefficients, producing a 48-bit signed result. Multiplier slices in the target fabric accept at most 22x22 operands, so a 32x16 product is never formed. Each sample is split into a signed upper 16-bit half and an unsigned lower 16-bit half. Each half is multiplied by the tap coefficient in its own 16x16 path. The five upper-half products and the five lower-half products are summed separately. The final output is the upper sum shifted left by 16 plus the lower sum.

A sample is offered with `in_valid`. The newest sample and the four before it form the window, and tap 0 always weights the newest sample. The result appears with `out_valid` a fixed four cycles later. A parameter selects the coefficient source. With writable coefficients, a small write port loads one tap per cycle, and a snapshot of all taps is taken when each sample is accepted. With fixed coefficients, the taps come from a constant table and no coefficient registers exist.

Top module: `fir5_split`

## Requirements
- R1: For each accepted sample x[n], `out_result` equals the low 48 bits of the sum over k = 0..4 of tap[k] * x[n-k]. Samples and taps are two's-complement, tap 0 weights the newest sample, and the tap value is packed at bits [16k+15:16k] of `FIXED_TABLE`.
- R2: `out_valid` is high in exactly the cycle four clock edges after the edge that sampled `in_valid` high. Every accepted sample gives exactly one output, including back-to-back samples.
- R3: A cycle with `in_valid` low shifts nothing into the window. While `out_valid` is low, `out_result` keeps its previous value.
- R4: The lower 16 bits of a sample count as an unsigned magnitude. Sample 0x0000_8000 with tap 0 = 1 and zero history gives +32768.
- R5: With writable taps, `cw_en` high loads `cw_data` into tap `cw_idx` at the clock edge. A new tap value applies from the first sample accepted after the write cycle. A sample accepted in the same cycle as the write, or already in flight, uses the old value.
- R6: A write with `cw_idx` of 5, 6 or 7 changes no tap.
- R7: While `rst_n` is low, `out_valid` is 0 and `out_result` is 0. Reset clears the window to zero history and clears all writable taps to 0.
- R8: With `FIXED_COEF` = 1, the taps equal `FIXED_TABLE` and the write port has no effect.
- R9: Sums beyond the 48-bit range wrap modulo 2^48 with no saturation. Five samples of 0x8000_0000 with all taps at -32768 give 48'h4000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 32 | Signed input sample |
| cw_en | input | 1 | Tap write strobe |
| cw_idx | input | 3 | Tap index to write |
| cw_data | input | 16 | Signed tap value |
| out_valid | output | 1 | Result strobe |
| out_result | output | 48 | Signed filter output |

## Verification
The hardest case to reach from the ports is a tap write that lands while samples are still in the pipeline, or in the very cycle a sample is accepted. Only the snapshot rule decides which tap value those samples see. The stimulus mixes random writes with back-to-back samples and random idle gaps. A directed sequence writes a tap in the same cycle as a sample and then immediately before the next one. The bench model keeps a snapshot of the taps for each accepted sample, so any leak of a new tap into an older sample shows up in the compared result. Full-scale negative and positive samples and taps are forced often, which drives the split halves and the 48-bit wrap to their extremes.

// File: rtl/fir5_pkg.sv
package fir5_pkg;
  localparam int unsigned TAPS_DEF     = 5;
  localparam int unsigned SAMPLE_W_DEF = 32;
  localparam int unsigned COEF_W_DEF   = 16;
  localparam int unsigned OUT_W_DEF    = 48;
  localparam int unsigned LATENCY      = 4;
endpackage

// File: rtl/fir5_coef_bank.sv
module fir5_coef_bank #(
  parameter int unsigned TAPS   = 5,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned IDX_W  = 3,
  parameter bit          FIXED  = 1'b0,
  parameter logic [TAPS*COEF_W-1:0] TABLE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [COEF_W-1:0]        wr_data,
  output logic [TAPS*COEF_W-1:0]   coef_act
);
  generate
    if (FIXED) begin : g_fixed
      assign coef_act = TABLE;
    end else begin : g_prog
      logic [TAPS*COEF_W-1:0] reg_q, reg_d;
      logic [TAPS*COEF_W-1:0] act_q, act_d;

      always_comb begin
        reg_d = reg_q;
        for (int k = 0; k < int'(TAPS); k++) begin
          if (wr_en && (int'(wr_idx) == k)) reg_d[k*COEF_W +: COEF_W] = wr_data;
        end
        act_d = take ? reg_q : act_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          reg_q <= '0;
          act_q <= '0;
        end else begin
          reg_q <= reg_d;
          act_q <= act_d;
        end
      end

      assign coef_act = act_q;
    end
  endgenerate
endmodule

// File: rtl/fir5_window.sv
module fir5_window #(
  parameter int unsigned TAPS = 5,
  parameter int unsigned W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [W-1:0]      din,
  output logic [TAPS*W-1:0] win
);
  logic [TAPS*W-1:0] win_q, win_d;

  always_comb begin
    win_d = win_q;
    if (shift_en) begin
      win_d[0 +: W] = din;
      for (int k = 1; k < int'(TAPS); k++) win_d[k*W +: W] = win_q[(k-1)*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign win = win_q;
endmodule

// File: rtl/fir5_half_mac.sv
module fir5_half_mac #(
  parameter int unsigned TAPS        = 5,
  parameter int unsigned HALF_W      = 16,
  parameter int unsigned COEF_W      = 16,
  parameter bit          SIGNED_HALF = 1'b1,
  parameter int unsigned PROD_W      = HALF_W + 1 + COEF_W,
  parameter int unsigned SUM_W       = PROD_W + $clog2(TAPS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en_prod,
  input  logic                      en_sum,
  input  logic [TAPS*HALF_W-1:0]    halves,
  input  logic [TAPS*COEF_W-1:0]    coefs,
  output logic signed [SUM_W-1:0]   sum
);
  logic [TAPS*PROD_W-1:0] prod_d, prod_q;
  logic signed [SUM_W-1:0] sum_d, sum_q;

  always_comb begin
    for (int k = 0; k < int'(TAPS); k++) begin
      logic [HALF_W-1:0]        h;
      logic [COEF_W-1:0]        c;
      logic                     sb;
      logic signed [PROD_W-1:0] a_w, c_w, p;
      h   = halves[k*HALF_W +: HALF_W];
      c   = coefs[k*COEF_W +: COEF_W];
      sb  = SIGNED_HALF ? h[HALF_W-1] : 1'b0;
      a_w = {{(PROD_W-HALF_W){sb}}, h};
      c_w = {{(PROD_W-COEF_W){c[COEF_W-1]}}, c};
      p   = a_w * c_w;
      prod_d[k*PROD_W +: PROD_W] = en_prod ? p : prod_q[k*PROD_W +: PROD_W];
    end
  end

  always_comb begin
    logic signed [SUM_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < int'(TAPS); k++) begin
      acc = acc + {{(SUM_W-PROD_W){prod_q[k*PROD_W+PROD_W-1]}}, prod_q[k*PROD_W +: PROD_W]};
    end
    sum_d = en_sum ? acc : sum_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      sum_q  <= '0;
    end else begin
      prod_q <= prod_d;
      sum_q  <= sum_d;
    end
  end

  assign sum = sum_q;
endmodule

// File: rtl/fir5_split.sv
module fir5_split
  import fir5_pkg::*;
#(
  parameter int unsigned TAPS     = TAPS_DEF,
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned COEF_W   = COEF_W_DEF,
  parameter int unsigned OUT_W    = OUT_W_DEF,
  parameter bit          FIXED_COEF = 1'b0,
  parameter logic [TAPS*COEF_W-1:0] FIXED_TABLE = 80'h0005_0004_0003_0002_0001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                cw_en,
  input  logic [2:0]          cw_idx,
  input  logic [COEF_W-1:0]   cw_data,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_result
);
  localparam int unsigned HALF_W = SAMPLE_W / 2;
  localparam int unsigned PROD_W = HALF_W + 1 + COEF_W;
  localparam int unsigned SUM_W  = PROD_W + $clog2(TAPS);

  logic [TAPS*SAMPLE_W-1:0] win;
  logic [TAPS*COEF_W-1:0]   coef_act;
  logic [TAPS*HALF_W-1:0]   hi_halves, lo_halves;
  logic signed [SUM_W-1:0]  hi_sum, lo_sum;

  logic v_win_q, v_prod_q, v_sum_q, v_out_q;
  logic [OUT_W-1:0] res_q, res_d;

  fir5_window #(.TAPS(TAPS), .W(SAMPLE_W)) u_win (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(in_sample), .win(win)
  );

  fir5_coef_bank #(
    .TAPS(TAPS), .COEF_W(COEF_W), .IDX_W(3), .FIXED(FIXED_COEF), .TABLE(FIXED_TABLE)
  ) u_coef (
    .clk(clk), .rst_n(rst_n), .take(in_valid), .wr_en(cw_en),
    .wr_idx(cw_idx), .wr_data(cw_data), .coef_act(coef_act)
  );

  generate
    for (genvar k = 0; k < int'(TAPS); k++) begin : g_split
      assign hi_halves[k*HALF_W +: HALF_W] = win[k*SAMPLE_W + HALF_W +: HALF_W];
      assign lo_halves[k*HALF_W +: HALF_W] = win[k*SAMPLE_W +: HALF_W];
    end
  endgenerate

  fir5_half_mac #(
    .TAPS(TAPS), .HALF_W(HALF_W), .COEF_W(COEF_W), .SIGNED_HALF(1'b1),
    .PROD_W(PROD_W), .SUM_W(SUM_W)
  ) u_hi (
    .clk(clk), .rst_n(rst_n), .en_prod(v_win_q), .en_sum(v_prod_q),
    .halves(hi_halves), .coefs(coef_act), .sum(hi_sum)
  );

  fir5_half_mac #(
    .TAPS(TAPS), .HALF_W(HALF_W), .COEF_W(COEF_W), .SIGNED_HALF(1'b0),
    .PROD_W(PROD_W), .SUM_W(SUM_W)
  ) u_lo (
    .clk(clk), .rst_n(rst_n), .en_prod(v_win_q), .en_sum(v_prod_q),
    .halves(lo_halves), .coefs(coef_act), .sum(lo_sum)
  );

  always_comb begin
    logic [OUT_W-1:0] hi_ext, lo_ext;
    hi_ext = {{(OUT_W-SUM_W){hi_sum[SUM_W-1]}}, hi_sum};
    lo_ext = {{(OUT_W-SUM_W){lo_sum[SUM_W-1]}}, lo_sum};
    res_d  = v_sum_q ? ((hi_ext << HALF_W) + lo_ext) : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_win_q  <= 1'b0;
      v_prod_q <= 1'b0;
      v_sum_q  <= 1'b0;
      v_out_q  <= 1'b0;
      res_q    <= '0;
    end else begin
      v_win_q  <= in_valid;
      v_prod_q <= v_win_q;
      v_sum_q  <= v_prod_q;
      v_out_q  <= v_sum_q;
      res_q    <= res_d;
    end
  end

  assign out_valid  = v_out_q;
  assign out_result = res_q;
endmodule

// File: rtl/fir5_split_chk.sv
module fir5_split_chk #(
  parameter int unsigned TAPS   = 5,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned OUT_W  = 48
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic [OUT_W-1:0]       out_result,
  input logic [TAPS*COEF_W-1:0] coef_act
);
  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R2: every accepted sample yields a result four edges later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##4 out_valid);

  // R2: no result without a sample four edges earlier
  p_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 3'd4) && out_valid) |-> $past(in_valid, 4));

  // R3: output holds between results
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result));

  // R5: tap snapshot moves only when a sample is accepted
  p_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(coef_act));

  // R7: outputs cleared while reset is held
  p_reset_r7: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && (out_result == '0)));
endmodule

bind fir5_split fir5_split_chk #(
  .TAPS(TAPS), .COEF_W(COEF_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_result(out_result), .coef_act(coef_act)
);

// File: tb/sim_fir5_split.sv
module sim_fir5_split;
  typedef longint arr5_t [5];

  localparam logic [79:0] FTAB = 80'h8000_7FFF_FFFF_1234_0003;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_sample;
  logic        cw_en;
  logic [2:0]  cw_idx;
  logic [15:0] cw_data;
  logic        ov0, ov1;
  logic [47:0] res0, res1;

  fir5_split u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(cw_data),
    .out_valid(ov0), .out_result(res0)
  );

  fir5_split #(.FIXED_COEF(1'b1), .FIXED_TABLE(FTAB)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(cw_data),
    .out_valid(ov1), .out_result(res1)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  string tag = "R1";
  arr5_t hist, coef0, coefF;
  logic [47:0] q0[$];
  logic [47:0] q1[$];
  int qdue[$];
  logic [47:0] last0, last1;

  function automatic logic [47:0] ref_y(arr5_t h, arr5_t c);
    longint acc = 0;
    for (int k = 0; k < 5; k++) acc += h[k] * c[k];
    return acc[47:0];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic observe();
    if (ov0) begin
      if (q0.size() == 0) chk(1'b0, "R2", "unexpected out_valid", 48'd1, 48'd0);
      else begin
        logic [47:0] e;
        int d;
        e = q0.pop_front();
        d = qdue.pop_front();
        chk(d == cyc, "R2", "latency cycle", 48'(cyc), 48'(d));
        chk(res0 === e, tag, "result", res0, e);
      end
      last0 = res0;
    end else begin
      chk(res0 === last0, "R3", "hold while idle", res0, last0);
      if (qdue.size() != 0) chk(qdue[0] != cyc, "R2", "missing out_valid", 48'd0, 48'd1);
    end
    if (ov1) begin
      if (q1.size() == 0) chk(1'b0, "R8", "unexpected fixed out_valid", 48'd1, 48'd0);
      else begin
        logic [47:0] e;
        e = q1.pop_front();
        chk(res1 === e, "R8", "fixed-tap result", res1, e);
      end
    end
  endtask

  task automatic step(bit v, logic [31:0] s, bit we, int idx, logic [15:0] d);
    @(negedge clk);
    cyc++;
    observe();
    in_valid  = v;
    in_sample = s;
    cw_en     = we;
    cw_idx    = idx[2:0];
    cw_data   = d;
    if (v) begin
      for (int k = 4; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'($signed(s));
      q0.push_back(ref_y(hist, coef0));
      q1.push_back(ref_y(hist, coefF));
      qdue.push_back(cyc + 4);
    end
    if (we && idx < 5) coef0[idx] = longint'($signed(d));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'd0, 1'b0, 0, 16'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0; in_sample = '0; cw_en = 1'b0; cw_idx = '0; cw_data = '0;
    for (int k = 0; k < 5; k++) begin hist[k] = 0; coef0[k] = 0; end
    q0.delete(); q1.delete(); qdue.delete();
    last0 = '0; last1 = '0;
    @(negedge clk);
    @(negedge clk);
    chk(ov0 === 1'b0, "R7", "out_valid in reset", 48'(ov0), 48'd0);
    chk(res0 === 48'd0, "R7", "out_result in reset", res0, 48'd0);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] pick_s();
    case ($urandom % 8)
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'h0000_FFFF;
      3: return 32'hFFFF_0000;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [15:0] pick_c();
    case ($urandom % 6)
      0: return 16'h8000;
      1: return 16'h7FFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    in_valid = 1'b0; in_sample = '0; cw_en = 1'b0; cw_idx = '0; cw_data = '0;
    for (int k = 0; k < 5; k++) coefF[k] = longint'($signed(FTAB[k*16 +: 16]));
    do_reset();

    // R1: impulse response after loading taps 1..5
    tag = "R1";
    for (int k = 0; k < 5; k++) step(1'b0, 32'd0, 1'b1, k, 16'(k + 1));
    step(1'b1, 32'd1, 1'b0, 0, 16'd0);
    for (int k = 0; k < 4; k++) step(1'b1, 32'd0, 1'b0, 0, 16'd0);
    idle(6);

    // R4: lower half is unsigned
    tag = "R4";
    for (int k = 0; k < 5; k++) step(1'b1, 32'd0, 1'b0, 0, 16'd0);
    step(1'b0, 32'd0, 1'b1, 0, 16'd1);
    step(1'b1, 32'h0000_8000, 1'b0, 0, 16'd0);
    step(1'b1, 32'h0000_FFFF, 1'b0, 0, 16'd0);
    idle(6);

    // R9: wrap on overflow with full-scale values
    tag = "R9";
    for (int k = 0; k < 5; k++) step(1'b0, 32'd0, 1'b1, k, 16'h8000);
    for (int k = 0; k < 5; k++) step(1'b1, 32'h8000_0000, 1'b0, 0, 16'd0);
    for (int k = 0; k < 5; k++) step(1'b0, 32'd0, 1'b1, k, 16'h7FFF);
    for (int k = 0; k < 5; k++) step(1'b1, 32'h7FFF_FFFF, 1'b0, 0, 16'd0);
    idle(6);

    // R5: write in the same cycle as a sample, and while samples are in flight
    tag = "R5";
    step(1'b1, 32'h0001_0003, 1'b1, 0, 16'h0100);
    step(1'b1, 32'hFFFE_1234, 1'b1, 1, 16'hFF00);
    step(1'b0, 32'd0, 1'b1, 2, 16'h0042);
    step(1'b1, 32'h7654_8001, 1'b0, 0, 16'd0);
    idle(6);

    // R6: out-of-range tap indices are ignored
    tag = "R6";
    for (int k = 5; k < 8; k++) step(1'b0, 32'd0, 1'b1, k, 16'hABCD);
    for (int k = 0; k < 5; k++) step(1'b1, 32'h1111_2222 * (k + 1), 1'b0, 0, 16'd0);
    idle(6);

    // R3 / R1: random traffic with gaps and random writes
    tag = "R1";
    for (int i = 0; i < 4000; i++) begin
      bit v, we;
      v  = ($urandom % 10) < 7;
      we = ($urandom % 10) == 0;
      step(v, pick_s(), we, int'($urandom % 8), pick_c());
    end
    idle(6);

    // R7: reset mid-run clears history and taps
    do_reset();
    tag = "R7";
    step(1'b1, 32'h1234_5678, 1'b0, 0, 16'd0);
    step(1'b0, 32'd0, 1'b1, 0, 16'h0003);
    step(1'b1, 32'hFFFF_FFFF, 1'b0, 0, 16'd0);
    step(1'b1, 32'h0000_0002, 1'b0, 0, 16'd0);
    idle(6);
    chk(q0.size() == 0, "R2", "all results delivered", 48'(q0.size()), 48'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule